// File: doc/BRIEF.md
# I2C Line Conditioner and Bus Event Decoder

This block sits between the two raw pins of an I2C target and its protocol engine. Each raw line, SCL and SDA, is brought into the system clock domain through a two-stage synchroniser. It then passes through a persistence filter, which lets a new level through only once that level has held for a set number of consecutive clocks. Spikes shorter than the suppression window therefore never reach the decoder. The window length in clocks comes from two parameters: the system clock period and the spike width to reject. The defaults are a 5 ns clock and a 50 ns spike.

The decoder watches the two filtered lines and produces four single-cycle strobes:

- **Start:** SDA falls while SCL stays high.
- **Stop:** SDA rises while SCL stays high.
- **Sample:** SCL rises. The engine captures the incoming bit on this strobe.
- **Update:** SCL falls. The engine changes its outgoing bit on this strobe, so that bit is stable for the whole following high phase.

The engine's pull-low request is returned as the open-drain output enable. The line is only ever pulled low or released and is never driven high.

Top module: `bus_line_conditioner`

## Requirements
- R1: After reset, both filtered lines read 1 (idle bus) and all four strobes read 0.
- R2: A raw line change that persists reaches the filtered output exactly FILT_LEN+2 clocks after the first rising clock edge that samples it. FILT_LEN is ceil(SPIKE_NS/CLK_NS), which is 10 by default. The filtered output still shows the old level one clock earlier.
- R3: A raw pulse that lasts fewer than FILT_LEN clocks leaves the filtered line unchanged. A pulse that lasts FILT_LEN clocks or longer passes.
- R4: A falling filtered SDA while filtered SCL stays high gives start_stb high for exactly one clock. That clock is the one after the filtered change.
- R5: A rising filtered SDA while filtered SCL stays high gives stop_stb high for exactly one clock.
- R6: A rising filtered SCL gives sample_stb high for exactly one clock, and filtered SCL is high while sample_stb is high.
- R7: A falling filtered SCL gives update_stb high for exactly one clock, and filtered SCL is low while update_stb is high.
- R8: An SDA change while filtered SCL is low produces neither a start nor a stop strobe.
- R9: At most one of the four strobes is high in any clock. A sample strobe never coincides with a start or stop.
- R10: sda_oe equals sda_pull_low in the same cycle. A value of 1 means the line is pulled low; 0 means the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_raw | input | 1 | Raw SCL pin level |
| sda_raw | input | 1 | Raw SDA pin level |
| sda_pull_low | input | 1 | Pull-low request from the protocol engine |
| scl_filt | output | 1 | Synchronised, filtered SCL |
| sda_filt | output | 1 | Synchronised, filtered SDA |
| start_stb | output | 1 | One-clock start-condition strobe |
| stop_stb | output | 1 | One-clock stop-condition strobe |
| sample_stb | output | 1 | One-clock strobe on SCL rising edge |
| update_stb | output | 1 | One-clock strobe on SCL falling edge |
| sda_oe | output | 1 | Open-drain enable for SDA (1 = pull low) |

## Verification
Both lines are swept with isolated pulses whose widths run from one clock up to two clocks beyond the window. This separates an off-by-one in the persistence count from a correct threshold, and it shows that a suppressed SCL spike yields no sample or update strobe. A single SDA fall with SCL high is timed cycle by cycle, which pins down the filter latency and the start strobe position. Several data bytes (all zeros, all ones, alternating bits and mixed patterns) are clocked in with SDA changing only while SCL is low. Each byte is rebuilt from the sample strobes, and this pattern must produce no start or stop strobe. A final release of SDA with SCL high must produce one stop strobe.

// File: rtl/bus_line_pkg.sv
package bus_line_pkg;

    // registered state of the bus event decoder
    typedef struct packed {
        logic scl_prev;
        logic sda_prev;
        logic start;
        logic stop;
        logic sample;
        logic update;
    } evt_state_t;

    // number of clocks a level must persist to pass the filter
    function automatic int unsigned persist_clocks(input int unsigned spike_ns,
                                                   input int unsigned clk_ns);
        return (spike_ns + clk_ns - 1) / clk_ns;
    endfunction

endpackage

// File: rtl/bus_line_filter.sv
module bus_line_filter #(
    parameter int unsigned LEN = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic level
);
    localparam int unsigned CW = $clog2(LEN + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          lvl;
        logic [CW-1:0] cnt;
    } flt_state_t;

    flt_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw;
        st_d.s2 = st_q.s1;
        if (st_q.s2 != st_q.lvl) begin
            if (st_q.cnt == CW'(LEN - 1)) begin
                st_d.lvl = st_q.s2;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: 1'b1, s2: 1'b1, lvl: 1'b1, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.lvl;

    // R3: a flip is only allowed once the persistence count has run out
    p_full_window_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.lvl) |-> $past(st_q.cnt) == CW'(LEN - 1));

    // R2: the new filtered level is the level the synchroniser held
    p_level_from_sync_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.lvl) |-> st_q.lvl == $past(st_q.s2));

endmodule

// File: rtl/bus_event_decode.sv
module bus_event_decode
    import bus_line_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic start_stb,
    output logic stop_stb,
    output logic sample_stb,
    output logic update_stb
);
    evt_state_t ev_d, ev_q;

    always_comb begin
        logic scl_hold;
        ev_d          = ev_q;
        ev_d.scl_prev = scl;
        ev_d.sda_prev = sda;
        scl_hold      = ev_q.scl_prev & scl;
        ev_d.start    = scl_hold &  ev_q.sda_prev & ~sda;
        ev_d.stop     = scl_hold & ~ev_q.sda_prev &  sda;
        ev_d.sample   = ~ev_q.scl_prev & scl & ~(ev_d.start | ev_d.stop);
        ev_d.update   =  ev_q.scl_prev & ~scl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q <= '{scl_prev: 1'b1, sda_prev: 1'b1, start: 1'b0,
                      stop: 1'b0, sample: 1'b0, update: 1'b0};
        end else begin
            ev_q <= ev_d;
        end
    end

    assign start_stb  = ev_q.start;
    assign stop_stb   = ev_q.stop;
    assign sample_stb = ev_q.sample;
    assign update_stb = ev_q.update;

    p_one_event_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_stb, stop_stb, sample_stb, update_stb}));

    p_start_lines_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        start_stb |-> (scl && !sda));

    p_start_single_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        start_stb |=> !start_stb);

    p_stop_lines_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        stop_stb |-> (scl && sda));

    p_stop_single_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        stop_stb |=> !stop_stb);

    p_sample_high_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> scl);

    p_update_low_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        update_stb |-> !scl);

endmodule

// File: rtl/bus_line_conditioner.sv
module bus_line_conditioner
    import bus_line_pkg::*;
#(
    parameter int unsigned CLK_NS   = 5,
    parameter int unsigned SPIKE_NS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    input  logic sda_pull_low,
    output logic scl_filt,
    output logic sda_filt,
    output logic start_stb,
    output logic stop_stb,
    output logic sample_stb,
    output logic update_stb,
    output logic sda_oe
);
    localparam int unsigned FILT_LEN = persist_clocks(SPIKE_NS, CLK_NS);
    localparam int unsigned NLINES   = 2;

    logic [NLINES-1:0] raw_bus;
    logic [NLINES-1:0] filt_bus;

    assign raw_bus = {sda_raw, scl_raw};

    for (genvar gi = 0; gi < NLINES; gi++) begin : g_line
        bus_line_filter #(.LEN(FILT_LEN)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_bus[gi]),
            .level (filt_bus[gi])
        );
    end

    assign scl_filt = filt_bus[0];
    assign sda_filt = filt_bus[1];

    bus_event_decode u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl        (scl_filt),
        .sda        (sda_filt),
        .start_stb  (start_stb),
        .stop_stb   (stop_stb),
        .sample_stb (sample_stb),
        .update_stb (update_stb)
    );

    // open drain: enable means pull low, never drive high
    assign sda_oe = sda_pull_low;

endmodule

// File: tb/bus_line_conditioner_tb.sv
module bus_line_conditioner_tb;
    localparam int CLK_NS   = 5;
    localparam int SPIKE_NS = 50;
    localparam int N        = (SPIKE_NS + CLK_NS - 1) / CLK_NS;
    localparam int SETTLE   = N + 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_raw = 1'b1, sda_raw = 1'b1, sda_pull_low = 1'b0;
    logic scl_filt, sda_filt, start_stb, stop_stb, sample_stb, update_stb, sda_oe;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    int n_start = 0, n_stop = 0, n_sample = 0, n_update = 0;
    int n_sda_low = 0, n_scl_high = 0;
    logic [7:0] cap = '0;

    always #2.5 clk = ~clk;

    bus_line_conditioner #(.CLK_NS(CLK_NS), .SPIKE_NS(SPIKE_NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_raw), .sda_raw(sda_raw),
        .sda_pull_low(sda_pull_low), .scl_filt(scl_filt), .sda_filt(sda_filt),
        .start_stb(start_stb), .stop_stb(stop_stb), .sample_stb(sample_stb),
        .update_stb(update_stb), .sda_oe(sda_oe)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            n_start    += int'(start_stb);
            n_stop     += int'(stop_stb);
            n_sample   += int'(sample_stb);
            n_update   += int'(update_stb);
            n_sda_low  += int'(!sda_filt);
            n_scl_high += int'(scl_filt);
            if (sample_stb) cap = {cap[6:0], sda_filt};
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        int s0, u0, st0, sp0;
        s0 = n_sample; u0 = n_update; st0 = n_start; sp0 = n_stop;
        for (int i = 7; i >= 0; i--) begin
            sda_raw = b[i];
            wait_neg(SETTLE);
            scl_raw = 1'b1;
            wait_neg(SETTLE);
            scl_raw = 1'b0;
            wait_neg(SETTLE);
        end
        chk(cap == b, "R6 captured byte", int'(cap), int'(b));
        chk(n_sample - s0 == 8, "R6 sample count", n_sample - s0, 8);
        chk(n_update - u0 == 8, "R7 update count", n_update - u0, 8);
        chk((n_start - st0) + (n_stop - sp0) == 0, "R8 no start/stop in data",
            (n_start - st0) + (n_stop - sp0), 0);
    endtask

    initial begin
        int a, b, c;
        wait_neg(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(scl_filt && sda_filt, "R1 idle lines", int'({scl_filt, sda_filt}), 3);
        chk({start_stb, stop_stb, sample_stb, update_stb} == 4'b0, "R1 strobes low",
            int'({start_stb, stop_stb, sample_stb, update_stb}), 0);

        // R10 open-drain enable
        sda_pull_low = 1'b1; #1;
        chk(sda_oe == 1'b1, "R10 pull low", int'(sda_oe), 1);
        sda_pull_low = 1'b0; #1;
        chk(sda_oe == 1'b0, "R10 release", int'(sda_oe), 0);
        @(negedge clk);

        // R2 latency and R4 start timing: SDA falls with SCL high
        a = n_start;
        sda_raw = 1'b0;
        wait_neg(N + 1);
        chk(sda_filt == 1'b1, "R2 old level one clock early", int'(sda_filt), 1);
        @(negedge clk);
        chk(sda_filt == 1'b0, "R2 new level at N+2", int'(sda_filt), 0);
        chk(start_stb == 1'b0, "R4 no start yet", int'(start_stb), 0);
        @(negedge clk);
        chk(start_stb == 1'b1, "R4 start strobe", int'(start_stb), 1);
        @(negedge clk);
        chk(start_stb == 1'b0, "R4 start single cycle", int'(start_stb), 0);
        wait_neg(SETTLE);
        chk(n_start - a == 1, "R4 start count", n_start - a, 1);

        // R7 SCL fall
        a = n_update;
        scl_raw = 1'b0;
        wait_neg(SETTLE);
        chk(n_update - a == 1, "R7 update on SCL fall", n_update - a, 1);
        sda_raw = 1'b1;
        wait_neg(SETTLE);

        // R3/R8 SDA pulse sweep, SCL low
        for (int w = 1; w <= N + 2; w++) begin
            a = n_sda_low; b = n_start; c = n_stop;
            sda_raw = 1'b0;
            wait_neg(w);
            sda_raw = 1'b1;
            wait_neg(SETTLE);
            chk((n_sda_low - a > 0) == (w >= N), "R3 SDA pulse filter",
                n_sda_low - a, (w >= N) ? w : 0);
            chk((n_start - b) + (n_stop - c) == 0, "R8 SDA toggle with SCL low",
                (n_start - b) + (n_stop - c), 0);
        end

        // R3/R6/R7 SCL pulse sweep, SDA high
        for (int w = 1; w <= N + 2; w++) begin
            a = n_scl_high; b = n_sample; c = n_update;
            scl_raw = 1'b1;
            wait_neg(w);
            scl_raw = 1'b0;
            wait_neg(SETTLE);
            chk((n_scl_high - a > 0) == (w >= N), "R3 SCL pulse filter",
                n_scl_high - a, (w >= N) ? w : 0);
            chk(n_sample - b == ((w >= N) ? 1 : 0), "R6 sample per SCL pulse",
                n_sample - b, (w >= N) ? 1 : 0);
            chk(n_update - c == ((w >= N) ? 1 : 0), "R7 update per SCL pulse",
                n_update - c, (w >= N) ? 1 : 0);
        end

        // R6/R8 data bytes
        send_byte(8'h00);
        send_byte(8'hFF);
        send_byte(8'hA5);
        send_byte(8'h5A);
        send_byte(8'h3C);

        // R5 stop: SDA low, SCL high, then SDA released
        sda_raw = 1'b0;
        wait_neg(SETTLE);
        a = n_sample; b = n_stop; c = n_start;
        scl_raw = 1'b1;
        wait_neg(SETTLE);
        chk(n_sample - a == 1, "R9 sample without start/stop", n_sample - a, 1);
        sda_raw = 1'b1;
        wait_neg(SETTLE);
        chk(n_stop - b == 1, "R5 stop strobe count", n_stop - b, 1);
        chk(n_start - c == 0, "R5 no start on rising SDA", n_start - c, 0);

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule